// File: doc/BRIEF.md
# Scan Chain with Output-Holding Test Points

This block is a shift register of mux-D scan cells. During shifting the register moves serial test data through its cells. During capture each cell loads one bit of the functional response. Each cell's flip-flop drives one bit of the stimulus vector that goes to the logic under test. A parameter gives every cell a type: plain, hold-low or hold-high.

While the test-point enable is high, the stimulus bit of a hold-low cell reads 0 and that of a hold-high cell reads 1. Shifting transitions inside those cells therefore do not reach the combinational logic. Plain cells always pass their flip-flop value. The serial output is taken straight from the last flip-flop, so the enable never disturbs the data being shifted.

The enable is a separate input from scan enable. The tester can lower it one cycle after the last shift and raise it again one cycle after capture. This keeps the release and re-arming of the held cells out of the shift cycles next to capture. A second parameter marks cells that sit on timing-critical paths. Such cells must stay plain, and any configuration that places a test point on one of them, or uses the reserved type code, stops at elaboration.

Top module: `scan_hold_chain`

## Requirements
- R1: When `scan_en` is 1, each rising clock edge loads `scan_in` into cell 0 and moves cell i's value into cell i+1.
- R2: When `scan_en` is 0, each rising clock edge loads `resp[i]` into cell i for every cell.
- R3: `scan_out` always equals the flip-flop value of the last cell, whatever the value of `tp_en`.
- R4: While `tp_en` is 0, `stim` equals the flip-flop contents bit for bit.
- R5: A cell whose 2-bit field `TP_KIND[2i+1:2i]` is 2'b01 (hold-low) drives `stim[i]` = 0 while `tp_en` is 1. The default places such cells at indices 1 and 4.
- R6: A cell whose field is 2'b10 (hold-high) drives `stim[i]` = 1 while `tp_en` is 1. The default places such cells at indices 2, 5 and 7.
- R7: A cell whose field is 2'b00 drives `stim[i]` from its flip-flop whatever the value of `tp_en`. The default plain cells are 0, 3 and 6.
- R8: A cell with its `CRIT_MASK` bit set must be plain, and its stimulus follows its flip-flop with `tp_en` at 1. A field of 2'b11, or a test point on a masked cell, is an elaboration error. By default cell 6 is masked.
- R9: While `rst_n` is 0 every flip-flop clears, so `scan_out` is 0 and `stim` is 0 when `tp_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low clear of all cells |
| scan_en | input | 1 | 1 selects the shift path, 0 selects capture |
| tp_en | input | 1 | Holds the outputs of marked cells at their constants |
| scan_in | input | 1 | Serial data into cell 0 |
| resp | input | N_CELLS | Functional response captured when not shifting |
| scan_out | output | 1 | Serial data from the last cell |
| stim | output | N_CELLS | Gated cell outputs toward the logic under test |

## Verification
The bench toggles `tp_en` between clock edges with no clock in between. A design that took `scan_out` from the gated path would then corrupt the serial stream, and one that gated the critical or plain cells would show held constants where flip-flop data belongs. Shift patterns load both 0 and 1 into every held cell. This exposes a swapped hold-low and hold-high polarity, as well as an enable that is ignored or inverted. Capture cycles with `tp_en` high confirm that the flip-flops still load the response underneath the held outputs, and the next release shows that data.

// File: rtl/scan_hold_chain.sv
`timescale 1ns/1ps
module scan_hold_chain #(
  parameter int N_CELLS = 8,
  parameter logic [2*N_CELLS-1:0] TP_KIND = 16'h8924,
  parameter logic [N_CELLS-1:0] CRIT_MASK = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               tp_en,
  input  logic               scan_in,
  input  logic [N_CELLS-1:0] resp,
  output logic               scan_out,
  output logic [N_CELLS-1:0] stim
);
  localparam logic [1:0] KIND_PLAIN = 2'b00;
  localparam logic [1:0] KIND_LOW   = 2'b01;
  localparam logic [1:0] KIND_HIGH  = 2'b10;

  logic [N_CELLS-1:0] q;
  logic [N_CELLS-1:0] d;

  genvar i;
  generate
    for (i = 0; i < N_CELLS; i++) begin : g_cell
      localparam logic [1:0] KIND = TP_KIND[2*i +: 2];

      if (KIND == 2'b11) begin : g_bad_code
        $error("scan_hold_chain: cell %0d uses reserved type code", i);
      end
      if (CRIT_MASK[i] && KIND != KIND_PLAIN) begin : g_bad_crit
        $error("scan_hold_chain: critical cell %0d carries a test point", i);
      end

      if (i == 0) begin : g_head
        assign d[i] = scan_en ? scan_in : resp[i];
      end else begin : g_link
        assign d[i] = scan_en ? q[i-1] : resp[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= d[i];
      end

      if (KIND == KIND_LOW) begin : g_low
        assign stim[i] = q[i] & ~tp_en;
      end else if (KIND == KIND_HIGH) begin : g_high
        assign stim[i] = q[i] | tp_en;
      end else begin : g_plain
        assign stim[i] = q[i];
      end
    end
  endgenerate

  assign scan_out = q[N_CELLS-1];
endmodule

// File: rtl/scan_hold_chain_chk.sv
`timescale 1ns/1ps
module scan_hold_chain_chk #(
  parameter int N_CELLS = 8,
  parameter logic [2*N_CELLS-1:0] TP_KIND = 16'h8924,
  parameter logic [N_CELLS-1:0] CRIT_MASK = 8'h40
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scan_en,
  input logic               tp_en,
  input logic               scan_in,
  input logic [N_CELLS-1:0] resp,
  input logic [N_CELLS-1:0] q,
  input logic [N_CELLS-1:0] stim,
  input logic               scan_out
);
  function automatic logic [N_CELLS-1:0] kind_mask(input logic [1:0] code);
    logic [N_CELLS-1:0] m;
    m = '0;
    for (int k = 0; k < N_CELLS; k++)
      if (TP_KIND[2*k +: 2] == code) m[k] = 1'b1;
    return m;
  endfunction

  localparam logic [N_CELLS-1:0] LOW_M   = kind_mask(2'b01);
  localparam logic [N_CELLS-1:0] HIGH_M  = kind_mask(2'b10);
  localparam logic [N_CELLS-1:0] PLAIN_M = ~(LOW_M | HIGH_M);

  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> q == {$past(q[N_CELLS-2:0]), $past(scan_in)});
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> q == $past(resp));
  p_scanout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_out == q[N_CELLS-1]);
  p_transparent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_en |-> stim == q);
  p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tp_en |-> (stim & LOW_M) == '0);
  p_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tp_en |-> (stim & HIGH_M) == HIGH_M);
  p_plain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stim & PLAIN_M) == (q & PLAIN_M));
  p_crit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stim & CRIT_MASK) == (q & CRIT_MASK));
endmodule

bind scan_hold_chain scan_hold_chain_chk #(
  .N_CELLS(N_CELLS), .TP_KIND(TP_KIND), .CRIT_MASK(CRIT_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .tp_en(tp_en),
  .scan_in(scan_in), .resp(resp), .q(q), .stim(stim), .scan_out(scan_out)
);

// File: tb/test_scan_hold_chain.sv
`timescale 1ns/1ps
module test_scan_hold_chain;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0;
  logic tp_en = 1'b0;
  logic scan_in = 1'b0;
  logic [N-1:0] resp = '0;
  logic scan_out;
  logic [N-1:0] stim;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [N-1:0] mq = '0;
  int kind [N] = '{0, 1, 2, 0, 1, 2, 0, 2};

  always #2.5 clk = ~clk;

  scan_hold_chain i_scan_hold_chain (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .tp_en(tp_en),
    .scan_in(scan_in), .resp(resp), .scan_out(scan_out), .stim(stim)
  );

  function automatic logic [N-1:0] exp_stim();
    logic [N-1:0] e;
    for (int k = 0; k < N; k++) begin
      if (tp_en && kind[k] == 1)      e[k] = 1'b0;
      else if (tp_en && kind[k] == 2) e[k] = 1'b1;
      else                            e[k] = mq[k];
    end
    return e;
  endfunction

  task automatic compare(input string tag);
    logic [N-1:0] e;
    e = exp_stim();
    checks++;
    if (stim !== e) begin
      errors++;
      $display("FAIL %s stim actual %b expected %b", tag, stim, e);
    end
    checks++;
    if (scan_out !== mq[N-1]) begin
      errors++;
      $display("FAIL R3 %s scan_out actual %b expected %b", tag, scan_out, mq[N-1]);
    end
  endtask

  task automatic step(input logic se, input logic tpe, input logic si,
                      input logic [N-1:0] r, input string tag);
    scan_en = se; tp_en = tpe; scan_in = si; resp = r;
    @(posedge clk);
    if (se) mq = {mq[N-2:0], si};
    else    mq = r;
    #1;
    compare(tag);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat;
    repeat (3) @(negedge clk);
    compare("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);

    pat = 8'b1011_0010;
    for (int k = 0; k < N; k++) step(1'b1, 1'b0, pat[k], '0, "R1 R4 shift open");
    pat = 8'b0110_1101;
    for (int k = 0; k < N; k++) step(1'b1, 1'b1, pat[k], '0, "R1 R5 R6 R7 R8 shift held");
    for (int k = 0; k < N; k++) step(1'b1, 1'b1, 1'b1, '0, "R1 R5 R6 shift ones held");

    step(1'b0, 1'b0, 1'b0, 8'hA5, "R2 R4 capture open");
    step(1'b0, 1'b1, 1'b0, 8'h5A, "R2 R5 R6 R8 capture held");
    tp_en = 1'b0; #1; compare("R4 release without clock");
    tp_en = 1'b1; #1; compare("R3 R5 R6 R7 arm without clock");
    step(1'b0, 1'b1, 1'b0, 8'hFF, "R2 R6 capture ones held");
    step(1'b0, 1'b1, 1'b0, 8'h00, "R2 R5 capture zeros held");
    tp_en = 1'b0; #1; compare("R2 R4 zeros visible");

    for (int k = 0; k < 60; k++) begin
      step(logic'($urandom_range(0, 3) != 0), logic'($urandom_range(0, 1)),
           logic'($urandom_range(0, 1)), N'($urandom), "R1 R2 R5 R6 R7 R8 mixed");
    end

    rst_n = 1'b0; tp_en = 1'b0; mq = '0; #1;
    compare("R9 reset again");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule